// File: doc/BRIEF.md
# Flash status bit updater

This block changes a single configuration bit held in one of the three status registers of a serial NOR flash. It does so without help from software. A host raises a one-cycle start request that carries three things: a 5-bit bit index, a set-or-clear flag and a 2-bit write style. The block first reads the register that holds the bit. If the bit already has the wanted value, the block stops there. If not, it sends a write-enable, writes the updated register contents, and then polls the busy flag until the flash finishes or a poll budget runs out. When the operation ends, the block pulses `rsp_done` for one cycle and drives a 2-bit result code alongside it.

On the flash side the block drives a byte-level command engine. Each command carries:
- an opcode;
- a flag that asks for one byte to be read back;
- a count of zero, one or two bytes to write.

The command is held until the engine acknowledges it, and the acknowledge may report a transfer fault. Pin timing and multi-line transfers belong to the engine, not to this block.

Result codes: 0 = success, 1 = transfer fault, 2 = busy timeout, 3 = bad request.

Top module: `flash_sr_bit_updater`

## Requirements
- R1: The index is split so that `req_index[4:3]` picks the target register and `req_index[2:0]` picks the bit within it. The first command reads the target register with opcode 0x05, 0x35 or 0x15 for register 0, 1 or 2. A read command has `cmd_rd`=1, `cmd_nbytes`=0 and `cmd_wdata`=0.
- R2: If the bit read back already equals `req_set`, the block finishes with code 0 after that single read and issues no other command.
- R3: With style 0, a write-enable (opcode 0x06, no data) is issued and then a one-byte write with opcode 0x01, 0x11 or 0x31 for register 0, 2 or 1. The new byte sits in `cmd_wdata[15:8]` and `cmd_wdata[7:0]` is 0. Every status write is directly preceded by a write-enable.
- R4: With style 1, before the write-enable the block reads the partner register. The partner is register 1 when register 0 is targeted, and register 0 when register 1 is targeted. The block then writes two bytes with opcode 0x01. The first byte goes in `cmd_wdata[15:8]` and is register 0's value, the second byte goes in `cmd_wdata[7:0]`, and the new value replaces the targeted byte.
- R5: Style 2 behaves as style 1, except that the partner read for a register-0 change is register 2. Its value becomes the second byte.
- R6: After the write, the block reads register 0 (opcode 0x05) repeatedly until bit 0 reads 0, and then finishes with code 0.
- R7: If `POLL_LIMIT` polls all report busy, the block finishes with code 2 after the last of them. At least `POLL_GAP` idle cycles separate consecutive polls.
- R8: A command acknowledged with `cmd_fail` ends the operation at once with code 1, and no further command is issued.
- R9: A request with style 3, with a register index of 3, or with style 1 or 2 aimed at register 2 finishes with code 3. `rsp_done` rises in the cycle after the start, and no command is issued.
- R10: `rsp_done` is a one-cycle pulse. A start that arrives while an operation is in progress is ignored: it adds no command and no extra done.
- R11: After reset, `rsp_done` and `cmd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start request, accepted only when idle |
| req_set | input | 1 | 1 sets the bit, 0 clears it |
| req_index | input | 5 | Register (bits 4:3) and bit (bits 2:0) |
| req_style | input | 2 | Status write style 0..2, 3 is illegal |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 2 | Result code, valid with rsp_done |
| cmd_valid | output | 1 | Command request, held until acknowledged |
| cmd_op | output | 8 | Command opcode |
| cmd_rd | output | 1 | Read one byte back |
| cmd_nbytes | output | 2 | Bytes to write (0..2) |
| cmd_wdata | output | 16 | Write bytes, first byte in [15:8] |
| cmd_ack | input | 1 | Command engine acknowledge |
| cmd_fail | input | 1 | Transfer fault, valid with cmd_ack |
| cmd_rdata | input | 8 | Read byte, valid with cmd_ack |

## Verification
The bench targets the cases where the partner register and the byte order differ between the two paired styles. A design that swapped them would write the untouched register's byte into the wrong slot, or read register 1 where register 2 is required. It also sets the busy phase one poll below the limit and exactly at the limit. An off-by-one poll counter would then either time out a flash that was about to finish or issue one poll too many. Faults are injected on the first read, on the write and on a poll, so a sequencer that continued after a fault would log extra commands. Illegal requests and a start raised in mid-operation check that a bad request never reaches the bus and that a second start cannot restart the sequence.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

    localparam int IDX_W = 5;
    localparam int REG_W = 2;
    localparam int BIT_W = 3;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR0 = 8'h05;
    localparam logic [7:0] OP_RDSR1 = 8'h35;
    localparam logic [7:0] OP_RDSR2 = 8'h15;
    localparam logic [7:0] OP_WRSR0 = 8'h01;
    localparam logic [7:0] OP_WRSR1 = 8'h31;
    localparam logic [7:0] OP_WRSR2 = 8'h11;

    typedef enum logic [1:0] {
        FLSR_OK       = 2'd0,
        FLSR_XFER     = 2'd1,
        FLSR_BUSY_TMO = 2'd2,
        FLSR_PARAM    = 2'd3
    } flsr_status_e;

    typedef enum logic [1:0] {
        WS_SINGLE    = 2'd0,
        WS_PAIR_NEXT = 2'd1,
        WS_PAIR_HIGH = 2'd2,
        WS_RSVD      = 2'd3
    } wr_style_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TGT,
        ST_RD_PART,
        ST_WREN,
        ST_WRITE,
        ST_POLL,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [7:0]  op;
        logic        rd;
        logic [1:0]  nbytes;
        logic [15:0] wdata;
    } flash_cmd_t;

    function automatic logic [7:0] rd_opcode(logic [REG_W-1:0] r);
        case (r)
            2'd0:    return OP_RDSR0;
            2'd1:    return OP_RDSR1;
            default: return OP_RDSR2;
        endcase
    endfunction

    function automatic logic [7:0] wr_opcode(logic [REG_W-1:0] r);
        case (r)
            2'd0:    return OP_WRSR0;
            2'd1:    return OP_WRSR1;
            default: return OP_WRSR2;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] partner_reg(wr_style_e s, logic [REG_W-1:0] r);
        if (r != 2'd0)
            return 2'd0;
        return (s == WS_PAIR_NEXT) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic req_legal(logic [1:0] s, logic [REG_W-1:0] r);
        return (s != 2'd3) && (r != 2'd3) && !((s != 2'd0) && (r == 2'd2));
    endfunction

endpackage

// File: rtl/flsr_payload.sv
module flsr_payload
    import flsr_pkg::*;
(
    input  wr_style_e        style,
    input  logic [REG_W-1:0] reg_sel,
    input  logic [7:0]       new_val,
    input  logic [7:0]       part_val,
    output flash_cmd_t       wr_cmd
);

    always_comb begin
        wr_cmd    = '0;
        wr_cmd.rd = 1'b0;
        if (style == WS_SINGLE) begin
            wr_cmd.op     = wr_opcode(reg_sel);
            wr_cmd.nbytes = 2'd1;
            wr_cmd.wdata  = {new_val, 8'h00};
        end else begin
            wr_cmd.op     = OP_WRSR0;
            wr_cmd.nbytes = 2'd2;
            wr_cmd.wdata  = (reg_sel == 2'd0) ? {new_val, part_val} : {part_val, new_val};
        end
    end

endmodule

// File: rtl/flsr_poll_ctl.sv
module flsr_poll_ctl #(
    parameter int POLL_LIMIT = 10000,
    parameter int POLL_GAP   = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic busy_seen,
    output logic last_poll,
    output logic gap_done
);

    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);

    logic [CNT_W-1:0] poll_cnt;
    logic [GAP_W-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else if (busy_seen) begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= GAP_W'(POLL_GAP);
        end else if (gap_cnt != '0) begin
            gap_cnt  <= gap_cnt - 1'b1;
        end
    end

    assign last_poll = (poll_cnt == CNT_W'(POLL_LIMIT - 1));
    assign gap_done  = (gap_cnt == '0);

    AST_POLL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < CNT_W'(POLL_LIMIT)); // R7

    AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        busy_seen |=> !gap_done); // R7

endmodule

// File: rtl/flash_sr_bit_updater.sv
module flash_sr_bit_updater
    import flsr_pkg::*;
#(
    parameter int POLL_LIMIT = 10000,
    parameter int POLL_GAP   = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_start,
    input  logic        req_set,
    input  logic [4:0]  req_index,
    input  logic [1:0]  req_style,
    output logic        rsp_done,
    output logic [1:0]  rsp_err,
    output logic        cmd_valid,
    output logic [7:0]  cmd_op,
    output logic        cmd_rd,
    output logic [1:0]  cmd_nbytes,
    output logic [15:0] cmd_wdata,
    input  logic        cmd_ack,
    input  logic        cmd_fail,
    input  logic [7:0]  cmd_rdata
);

    seq_state_e       state;
    logic [REG_W-1:0] reg_q;
    logic [BIT_W-1:0] bit_q;
    logic             set_q;
    wr_style_e        style_q;
    logic [7:0]       cur_q;
    logic [7:0]       part_q;
    logic [7:0]       new_val;
    flsr_status_e     err_q;
    logic             done_q;
    flash_cmd_t       wr_cmd;
    flash_cmd_t       cur_cmd;
    logic             ack_ok;
    logic             ack_bad;
    logic             poll_clr;
    logic             busy_seen;
    logic             last_poll;
    logic             gap_done;

    always_comb begin
        new_val        = cur_q;
        new_val[bit_q] = set_q;
    end

    flsr_payload u_payload (
        .style    (style_q),
        .reg_sel  (reg_q),
        .new_val  (new_val),
        .part_val (part_q),
        .wr_cmd   (wr_cmd)
    );

    always_comb begin
        cur_cmd = '0;
        case (state)
            ST_RD_TGT: begin
                cur_cmd.op = rd_opcode(reg_q);
                cur_cmd.rd = 1'b1;
            end
            ST_RD_PART: begin
                cur_cmd.op = rd_opcode(partner_reg(style_q, reg_q));
                cur_cmd.rd = 1'b1;
            end
            ST_WREN:  cur_cmd.op = OP_WREN;
            ST_WRITE: cur_cmd    = wr_cmd;
            ST_POLL: begin
                cur_cmd.op = OP_RDSR0;
                cur_cmd.rd = 1'b1;
            end
            default:  cur_cmd = '0;
        endcase
    end

    assign cmd_valid  = (state != ST_IDLE) && (state != ST_GAP);
    assign cmd_op     = cur_cmd.op;
    assign cmd_rd     = cur_cmd.rd;
    assign cmd_nbytes = cur_cmd.nbytes;
    assign cmd_wdata  = cur_cmd.wdata;

    assign ack_ok    = cmd_valid && cmd_ack && !cmd_fail;
    assign ack_bad   = cmd_valid && cmd_ack && cmd_fail;
    assign poll_clr  = (state == ST_WRITE) && ack_ok;
    assign busy_seen = (state == ST_POLL) && ack_ok && cmd_rdata[0] && !last_poll;

    flsr_poll_ctl #(
        .POLL_LIMIT (POLL_LIMIT),
        .POLL_GAP   (POLL_GAP)
    ) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (poll_clr),
        .busy_seen (busy_seen),
        .last_poll (last_poll),
        .gap_done  (gap_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            reg_q   <= '0;
            bit_q   <= '0;
            set_q   <= 1'b0;
            style_q <= WS_SINGLE;
            cur_q   <= '0;
            part_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= FLSR_OK;
        end else begin
            done_q <= 1'b0;
            if (state == ST_IDLE) begin
                if (req_start) begin
                    reg_q   <= req_index[4:3];
                    bit_q   <= req_index[2:0];
                    set_q   <= req_set;
                    style_q <= wr_style_e'(req_style);
                    if (!req_legal(req_style, req_index[4:3])) begin
                        done_q <= 1'b1;
                        err_q  <= FLSR_PARAM;
                    end else begin
                        state <= ST_RD_TGT;
                    end
                end
            end else if (ack_bad) begin
                done_q <= 1'b1;
                err_q  <= FLSR_XFER;
                state  <= ST_IDLE;
            end else begin
                case (state)
                    ST_RD_TGT: if (ack_ok) begin
                        cur_q <= cmd_rdata;
                        if (cmd_rdata[bit_q] == set_q) begin
                            done_q <= 1'b1;
                            err_q  <= FLSR_OK;
                            state  <= ST_IDLE;
                        end else begin
                            state <= (style_q == WS_SINGLE) ? ST_WREN : ST_RD_PART;
                        end
                    end
                    ST_RD_PART: if (ack_ok) begin
                        part_q <= cmd_rdata;
                        state  <= ST_WREN;
                    end
                    ST_WREN:  if (ack_ok) state <= ST_WRITE;
                    ST_WRITE: if (ack_ok) state <= ST_POLL;
                    ST_POLL: if (ack_ok) begin
                        if (!cmd_rdata[0]) begin
                            done_q <= 1'b1;
                            err_q  <= FLSR_OK;
                            state  <= ST_IDLE;
                        end else if (last_poll) begin
                            done_q <= 1'b1;
                            err_q  <= FLSR_BUSY_TMO;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_GAP;
                        end
                    end
                    ST_GAP: if (gap_done) state <= ST_POLL;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign rsp_done = done_q;
    assign rsp_err  = err_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R10

    AST_WREN_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid && (cmd_nbytes != 2'd0)) |-> ($past(cmd_op) == OP_WREN)); // R3

    AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ack && cmd_fail) |=> (rsp_done && rsp_err == FLSR_XFER && !cmd_valid)); // R8

    AST_PARAM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err == FLSR_PARAM) |-> !$past(cmd_valid)); // R9

    AST_TMO_AFTER_POLL: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err == FLSR_BUSY_TMO) |-> ($past(cmd_op) == OP_RDSR0 && $past(cmd_ack))); // R7

    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op))); // R8

endmodule

// File: tb/test_flash_sr_bit_updater.sv
module test_flash_sr_bit_updater;

    localparam int LIMIT = 6;
    localparam int GAP   = 5;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_start = 1'b0;
    logic        req_set = 1'b0;
    logic [4:0]  req_index = '0;
    logic [1:0]  req_style = '0;
    logic        rsp_done;
    logic [1:0]  rsp_err;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic        cmd_rd;
    logic [1:0]  cmd_nbytes;
    logic [15:0] cmd_wdata;
    logic        cmd_ack = 1'b0;
    logic        cmd_fail = 1'b0;
    logic [7:0]  cmd_rdata = '0;

    flash_sr_bit_updater #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) i_flash_sr_bit_updater (
        .clk(clk), .rst(rst), .req_start(req_start), .req_set(req_set),
        .req_index(req_index), .req_style(req_style), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rd(cmd_rd),
        .cmd_nbytes(cmd_nbytes), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
        .cmd_fail(cmd_fail), .cmd_rdata(cmd_rdata)
    );

    always #2 clk = ~clk;

    logic [7:0]  sr [0:2];
    int          busy_cfg = 0, busy_left = 0, err_at = -1;
    bit          wel = 0;
    logic [31:0] log_q[$];
    logic [31:0] exp_q[$];
    int          stamp_q[$];
    int          cyc = 0;
    int          n_tests = 0, n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(logic [7:0] op, logic rd, logic [1:0] n, logic [15:0] d);
        return {op, rd, n, 5'b0, d};
    endfunction

    function automatic logic [7:0] rdop(int r);
        return (r == 0) ? 8'h05 : (r == 1) ? 8'h35 : 8'h15;
    endfunction

    function automatic logic [7:0] wrop(int r);
        return (r == 0) ? 8'h01 : (r == 1) ? 8'h31 : 8'h11;
    endfunction

    // Flash command engine model: acknowledges after LAT cycles, logs every command.
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (cmd_ack) begin
                cmd_ack = 1'b0;
                cmd_fail = 1'b0;
                lat = 0;
            end else if (cmd_valid) begin
                lat++;
                if (lat >= LAT) begin
                    logic [7:0] v;
                    int r;
                    log_q.push_back({cmd_op, cmd_rd, cmd_nbytes, 5'b0, cmd_wdata});
                    stamp_q.push_back(cyc);
                    cmd_fail = (log_q.size() - 1 == err_at);
                    v = 8'h00;
                    if (!cmd_fail) begin
                        if (cmd_rd) begin
                            r = (cmd_op == 8'h05) ? 0 : (cmd_op == 8'h35) ? 1 : 2;
                            v = sr[r];
                            if (r == 0 && busy_left > 0) begin
                                v[0] = 1'b1;
                                busy_left--;
                            end
                        end else if (cmd_op == 8'h06) begin
                            wel = 1;
                        end else if (wel) begin
                            if (cmd_nbytes == 2'd2) begin
                                sr[0] = cmd_wdata[15:8];
                                sr[1] = cmd_wdata[7:0];
                            end else if (cmd_op == 8'h01) sr[0] = cmd_wdata[15:8];
                            else if (cmd_op == 8'h31) sr[1] = cmd_wdata[15:8];
                            else sr[2] = cmd_wdata[15:8];
                            busy_left = busy_cfg;
                            wel = 0;
                        end
                    end
                    cmd_rdata = v;
                    cmd_ack = 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Behavioural reference: expected command list and result code from the requirements.
    task automatic build(input int st, input int idx, input bit setv, input int busy,
                         input int errat, output int code);
        int rg, bt, p;
        logic [7:0] cur, nv, pv;
        rg = idx >> 3;
        bt = idx & 7;
        exp_q.delete();
        pv = 8'h00;
        if (st == 3 || rg == 3 || (st != 0 && rg == 2)) begin code = 3; return; end
        exp_q.push_back(mk(rdop(rg), 1'b1, 2'd0, 16'h0));
        if (errat == 0) begin code = 1; return; end
        cur = sr[rg];
        if (cur[bt] == setv) begin code = 0; return; end
        nv = cur;
        nv[bt] = setv;
        if (st != 0) begin
            p = (rg == 0) ? ((st == 1) ? 1 : 2) : 0;
            exp_q.push_back(mk(rdop(p), 1'b1, 2'd0, 16'h0));
            if (errat == exp_q.size() - 1) begin code = 1; return; end
            pv = sr[p];
        end
        exp_q.push_back(mk(8'h06, 1'b0, 2'd0, 16'h0));
        if (errat == exp_q.size() - 1) begin code = 1; return; end
        if (st == 0) exp_q.push_back(mk(wrop(rg), 1'b0, 2'd1, {nv, 8'h00}));
        else         exp_q.push_back(mk(8'h01, 1'b0, 2'd2, (rg == 0) ? {nv, pv} : {pv, nv}));
        if (errat == exp_q.size() - 1) begin code = 1; return; end
        for (int k = 1; k <= LIMIT; k++) begin
            exp_q.push_back(mk(8'h05, 1'b1, 2'd0, 16'h0));
            if (errat == exp_q.size() - 1) begin code = 1; return; end
            if (k > busy) begin code = 0; return; end
        end
        code = 2;
    endtask

    task automatic run(input string req, input int st, input int idx, input bit setv,
                       input int busy, input int errat, input bit intrude);
        int code, waitc, extra;
        busy_cfg = busy; busy_left = 0; err_at = errat; wel = 0;
        log_q.delete(); stamp_q.delete();
        build(st, idx, setv, busy, errat, code);
        @(negedge clk);
        req_style = 2'(st); req_index = 5'(idx); req_set = setv; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        if (code == 3) chk(rsp_done === 1'b1, {req, " done in cycle after start"}, 32'(rsp_done), 32'd1);
        waitc = 0;
        while (!rsp_done && waitc < 3000) begin
            if (intrude && waitc == 3) begin
                req_style = 2'd0; req_index = 5'd9; req_set = 1'b1; req_start = 1'b1;
            end else req_start = 1'b0;
            @(negedge clk);
            waitc++;
        end
        req_start = 1'b0;
        chk(rsp_done === 1'b1, {req, " done seen"}, 32'(rsp_done), 32'd1);
        chk(rsp_err === 2'(code), {req, " result code"}, 32'(rsp_err), 32'(code));
        chk(log_q.size() == exp_q.size(), {req, " command count"}, 32'(log_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
            chk(log_q[i] === exp_q[i], {req, " command word"}, log_q[i], exp_q[i]);
        @(negedge clk);
        chk(rsp_done === 1'b0, {req, " R10 done is one cycle"}, 32'(rsp_done), 32'd0);
        if (intrude) begin
            extra = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (cmd_valid || rsp_done) extra++;
            end
            chk(extra == 0, {req, " R10 ignored start left no activity"}, 32'(extra), 32'd0);
        end
    endtask

    task automatic set_sr(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        sr[0] = a; sr[1] = b; sr[2] = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        set_sr(8'h00, 8'h00, 8'h00);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_done === 1'b0, "R11 reset done", 32'(rsp_done), 32'd0);
        chk(cmd_valid === 1'b0, "R11 reset cmd_valid", 32'(cmd_valid), 32'd0);

        set_sr(8'h00, 8'h00, 8'h00); run("R1 R3 R6 style0 reg0", 0, 2, 1'b1, 2, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R1 R3 style0 reg1", 0, 9, 1'b1, 0, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'hFF); run("R1 R3 style0 reg2 clear", 0, 21, 1'b0, 1, -1, 1'b0);
        set_sr(8'h00, 8'h02, 8'h00); run("R2 already set", 0, 9, 1'b1, 0, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R2 already clear style1", 1, 3, 1'b0, 0, -1, 1'b0);
        set_sr(8'h10, 8'h5A, 8'h00); run("R4 style1 reg0", 1, 6, 1'b1, 1, -1, 1'b0);
        set_sr(8'h3C, 8'h00, 8'h00); run("R4 style1 reg1", 1, 9, 1'b1, 0, -1, 1'b0);
        set_sr(8'h80, 8'h11, 8'h66); run("R5 style2 reg0", 2, 7, 1'b0, 1, -1, 1'b0);
        set_sr(8'h24, 8'h00, 8'h99); run("R5 style2 reg1", 2, 14, 1'b1, 0, -1, 1'b0);

        set_sr(8'h00, 8'h00, 8'h00); run("R7 timeout", 0, 4, 1'b1, 20, -1, 1'b0);
        for (int k = stamp_q.size() - LIMIT + 1; k > 0 && k < stamp_q.size(); k++)
            chk(stamp_q[k] - stamp_q[k-1] >= GAP, "R7 poll spacing",
                32'(stamp_q[k] - stamp_q[k-1]), 32'(GAP));
        set_sr(8'h00, 8'h00, 8'h00); run("R6 busy one below limit", 0, 4, 1'b1, LIMIT - 1, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R7 busy at limit", 0, 4, 1'b1, LIMIT, -1, 1'b0);

        set_sr(8'h00, 8'h00, 8'h00); run("R8 fault on first read", 0, 4, 1'b1, 0, 0, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R8 fault on write", 0, 4, 1'b1, 0, 2, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R8 fault on poll", 0, 4, 1'b1, 3, 4, 1'b0);

        set_sr(8'h00, 8'h00, 8'h00); run("R9 style 3", 3, 4, 1'b1, 0, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R9 register 3", 0, 26, 1'b1, 0, -1, 1'b0);
        set_sr(8'h00, 8'h00, 8'h00); run("R9 paired style on reg2", 1, 17, 1'b1, 0, -1, 1'b0);

        set_sr(8'h00, 8'h00, 8'h00); run("R10 start while busy", 0, 12, 1'b1, 3, -1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule